// File: doc/BRIEF.md
# Multi-Lane Serial Flash Command Sequencer

The block plays out one serial flash command at a time on a bus of one, two or four data lanes. A command is made of up to four phases in a fixed order: an opcode byte, an optional address of three or four bytes, an optional run of dummy clocks and an optional read or write data phase. A 3-bit lane mode picks how many lanes each phase uses. The opcode, address and data phases can each have a different lane count. The block drives the serial clock, an active-low chip select and per-lane output enables, so the lanes can be tristated at the pads.

A register frontend sets up the command fields and pulses `start`. Write bytes come from a show-ahead byte source: the byte on `wr_data` is taken when the engine needs it, and `wr_ack` tells the source to move to the next byte. Read bytes are returned one at a time with a `rd_valid` pulse. At the end of the command the block pulses `done`. A start with an unsupported lane mode is refused and the block pulses `err`. The serial clock divider is fixed by a parameter.

Top module: `flash_lane_engine`

## Requirements
- R1: Lane counts per `io_mode` value, given as opcode/address/data: 0 = 1/1/1, 1 = 1/1/2, 2 = 1/2/2, 3 = 2/2/2, 5 = 1/1/4, 6 = 1/4/4, 7 = 4/4/4. `lane_oe` is always 0000, 0001, 0011 or 1111.
- R2: A start with `io_mode` = 4 is refused. `err` is high for exactly one cycle, in the cycle after the start. `cs_n` stays high, `sclk` does not toggle and `done` does not pulse.
- R3: The phases run in this order: opcode, address, dummy, data. The address phase runs only when `addr_en` = 1. It sends `addr[31:0]` when `addr4` = 1 and `addr[23:0]` otherwise. The dummy phase runs only when `dummy_bytes` > 0, and the data phase runs only when `data_en` = 1.
- R4: Every byte goes out most significant bit first. On a multi-lane phase, the highest enabled lane carries the highest bit of each clock's bit group: one lane sends bit 7 on lane 0; two lanes send bits 7:6 on lanes 1:0; four lanes send bits 7:4 on lanes 3:0.
- R5: The dummy phase lasts `dummy_bytes`*8/(data lane count) serial clocks, with `lane_oe` = 0.
- R6: The data phase moves `data_len_m1`+1 bytes. With `rd_nwr` = 1 it reads: all lanes are released and bits are sampled on the rising serial clock edge, from lane 1 when one lane is used. Each complete byte appears on `rd_data` with a one-cycle `rd_valid` pulse. With `rd_nwr` = 0 it writes: each byte is taken from `wr_data`, followed by a one-cycle `wr_ack`.
- R7: The bus runs in SPI mode 0. `sclk` idles low, each `sclk` high and low level lasts `HALF_DIV` clock cycles, and `lane_out` changes only while `sclk` is low.
- R8: `cs_n` is low for the whole command and `sclk` is never high while `cs_n` is high. `done` pulses for one cycle, in the cycle after `cs_n` returns high.
- R9: A `start` that arrives while a command is in progress is ignored.
- R10: After reset, `cs_n` = 1, and `sclk`, `lane_oe`, `done`, `err`, `wr_ack` and `rd_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle command start pulse |
| io_mode | input | 3 | Lane mode code |
| addr_en | input | 1 | Run the address phase |
| addr4 | input | 1 | 1 = four address bytes, 0 = three |
| opcode | input | 8 | Opcode byte |
| addr | input | 32 | Flash address |
| dummy_bytes | input | 3 | Dummy length in bytes |
| data_en | input | 1 | Run the data phase |
| rd_nwr | input | 1 | 1 = read data, 0 = write data |
| data_len_m1 | input | LEN_W | Data byte count minus one |
| wr_data | input | 8 | Head byte of the write stream |
| wr_ack | output | 1 | Write byte consumed |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` is valid |
| done | output | 1 | Command finished |
| err | output | 1 | Start refused (invalid mode) |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| lane_out | output | 4 | Lane output values |
| lane_oe | output | 4 | Lane output enables |
| lane_in | input | 4 | Lane input values |

## Verification
The assertions check the following on every cycle: the serial clock never runs without chip select, lane outputs hold steady while the clock is high, the lanes are released whenever a read byte lands, the enable pattern has a legal shape, a refused start keeps the bus quiet, and `done` follows the release of chip select. Only the bench scenarios can show the content of each command. That covers the per-mode lane counts, the bit order across lanes, the three- and four-byte addresses, the dummy clock count for each lane width, the read and write byte streams, and a second start being ignored in the middle of a command.

// File: rtl/flash_lane_pkg.sv
package flash_lane_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_OPC, PH_ADR, PH_DUM, PH_DAT, PH_DONE
  } phase_t;

  // lane width code: number of lanes = 1 << code
  typedef enum logic [1:0] {LW1 = 2'd0, LW2 = 2'd1, LW4 = 2'd2} lanes_t;

  function automatic logic mode_ok(input logic [2:0] m);
    return m != 3'd4;
  endfunction

  function automatic lanes_t opc_lanes(input logic [2:0] m);
    if (m == 3'd3) return LW2;
    if (m == 3'd7) return LW4;
    return LW1;
  endfunction

  function automatic lanes_t adr_lanes(input logic [2:0] m);
    if (m == 3'd2 || m == 3'd3) return LW2;
    if (m == 3'd6 || m == 3'd7) return LW4;
    return LW1;
  endfunction

  function automatic lanes_t dat_lanes(input logic [2:0] m);
    if (m == 3'd0) return LW1;
    if (m[2] == 1'b0) return LW2;
    return LW4;
  endfunction

  // serial clocks needed to move one byte at a given lane width
  function automatic logic [3:0] clocks_per_byte(input lanes_t w);
    case (w)
      LW2:     return 4'd4;
      LW4:     return 4'd2;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input lanes_t w);
    case (w)
      LW2:     return 4'b0011;
      LW4:     return 4'b1111;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic phase_t next_phase(input phase_t cur, input logic a_en,
                                        input logic d_en, input logic t_en);
    case (cur)
      PH_OPC:  return a_en ? PH_ADR : d_en ? PH_DUM : t_en ? PH_DAT : PH_DONE;
      PH_ADR:  return d_en ? PH_DUM : t_en ? PH_DAT : PH_DONE;
      PH_DUM:  return t_en ? PH_DAT : PH_DONE;
      default: return PH_DONE;
    endcase
  endfunction

endpackage

// File: rtl/fls_sclk_gen.sv
module fls_sclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise,
  output logic fall
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = run && (cnt == CW'(HALF_DIV - 1));
  assign rise = tick && !sclk;
  assign fall = tick && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/fls_lane_shift.sv
module fls_lane_shift
  import flash_lane_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  lanes_t     width,
  input  logic       shift_out,
  input  logic       sample_in,
  input  logic [3:0] lane_in,
  output logic [3:0] lane_bits,
  output logic [7:0] rx_byte
);
  logic [7:0] tx_sh;

  always_comb begin
    case (width)
      LW2:     lane_bits = {2'b00, tx_sh[7:6]};
      LW4:     lane_bits = tx_sh[7:4];
      default: lane_bits = {3'b000, tx_sh[7]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= 8'h00;
      rx_byte <= 8'h00;
    end else begin
      if (load)
        tx_sh <= load_byte;
      else if (shift_out) begin
        case (width)
          LW2:     tx_sh <= {tx_sh[5:0], 2'b00};
          LW4:     tx_sh <= {tx_sh[3:0], 4'h0};
          default: tx_sh <= {tx_sh[6:0], 1'b0};
        endcase
      end
      if (sample_in) begin
        case (width)
          LW2:     rx_byte <= {rx_byte[5:0], lane_in[1:0]};
          LW4:     rx_byte <= {rx_byte[3:0], lane_in};
          default: rx_byte <= {rx_byte[6:0], lane_in[1]};
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_lane_engine.sv
module flash_lane_engine
  import flash_lane_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int LEN_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       io_mode,
  input  logic             addr_en,
  input  logic             addr4,
  input  logic [7:0]       opcode,
  input  logic [31:0]      addr,
  input  logic [2:0]       dummy_bytes,
  input  logic             data_en,
  input  logic             rd_nwr,
  input  logic [LEN_W-1:0] data_len_m1,
  input  logic [7:0]       wr_data,
  output logic             wr_ack,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             err,
  output logic             sclk,
  output logic             cs_n,
  output logic [3:0]       lane_out,
  output logic [3:0]       lane_oe,
  input  logic [3:0]       lane_in
);
  localparam int CNT_W = LEN_W + 1;

  phase_t           phase, nxt_ph;
  lanes_t           w, nxt_w;
  logic [3:0]       clk_left;
  logic [CNT_W-1:0] byt_left, nxt_cnt;
  logic [31:0]      adr_sh;
  logic [2:0]       c_mode, c_dum;
  logic             c_adr_en, c_adr4, c_dat_en, c_rd;
  logic [LEN_W-1:0] c_len;

  // named internal events
  logic run, rise, fall, last_clk, ph_last, step_byte, start_go, take_wr;
  logic load;
  logic [7:0] load_byte;
  logic [3:0] lane_bits;

  assign run       = (phase == PH_OPC) || (phase == PH_ADR) ||
                     (phase == PH_DUM) || (phase == PH_DAT);
  assign last_clk  = fall && (clk_left == 4'd1);
  assign ph_last   = last_clk && (byt_left == CNT_W'(1));
  assign nxt_ph    = ph_last ? next_phase(phase, c_adr_en, c_dum != 3'd0, c_dat_en) : phase;
  assign step_byte = last_clk && (nxt_ph != PH_DONE);
  assign start_go  = (phase == PH_IDLE) && start && mode_ok(io_mode);
  assign take_wr   = step_byte && (nxt_ph == PH_DAT) && !c_rd;
  assign load      = start_go || step_byte;
  assign nxt_w     = (nxt_ph == PH_ADR) ? adr_lanes(c_mode) : dat_lanes(c_mode);

  always_comb begin
    if (start_go)                         load_byte = opcode;
    else if (nxt_ph == PH_ADR)            load_byte = adr_sh[31:24];
    else if (nxt_ph == PH_DAT && !c_rd)   load_byte = wr_data;
    else                                  load_byte = 8'h00;
  end

  always_comb begin
    case (nxt_ph)
      PH_ADR:  nxt_cnt = c_adr4 ? CNT_W'(4) : CNT_W'(3);
      PH_DUM:  nxt_cnt = CNT_W'(c_dum);
      default: nxt_cnt = CNT_W'(c_len) + CNT_W'(1);
    endcase
  end

  fls_sclk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .sclk(sclk), .rise(rise), .fall(fall)
  );

  fls_lane_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_byte(load_byte), .width(w),
    .shift_out(fall), .sample_in(rise && phase == PH_DAT && c_rd),
    .lane_in(lane_in), .lane_bits(lane_bits), .rx_byte(rd_data)
  );

  assign lane_oe  = ((phase == PH_OPC) || (phase == PH_ADR) ||
                     (phase == PH_DAT && !c_rd)) ? lane_mask(w) : 4'h0;
  assign lane_out = lane_bits & lane_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      w        <= LW1;
      clk_left <= 4'd0;
      byt_left <= '0;
      adr_sh   <= 32'h0;
      c_mode   <= 3'd0;
      c_dum    <= 3'd0;
      c_adr_en <= 1'b0;
      c_adr4   <= 1'b0;
      c_dat_en <= 1'b0;
      c_rd     <= 1'b0;
      c_len    <= '0;
      cs_n     <= 1'b1;
      done     <= 1'b0;
      err      <= 1'b0;
      wr_ack   <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      done     <= 1'b0;
      err      <= 1'b0;
      wr_ack   <= take_wr;
      rd_valid <= rise && (phase == PH_DAT) && c_rd && (clk_left == 4'd1);
      case (phase)
        PH_IDLE: begin
          if (start_go) begin
            c_mode   <= io_mode;
            c_dum    <= dummy_bytes;
            c_adr_en <= addr_en;
            c_adr4   <= addr4;
            c_dat_en <= data_en;
            c_rd     <= rd_nwr;
            c_len    <= data_len_m1;
            adr_sh   <= addr4 ? addr : {addr[23:0], 8'h00};
            w        <= opc_lanes(io_mode);
            clk_left <= clocks_per_byte(opc_lanes(io_mode));
            byt_left <= CNT_W'(1);
            cs_n     <= 1'b0;
            phase    <= PH_OPC;
          end else if (start) begin
            err <= 1'b1;
          end
        end
        PH_DONE: begin
          done  <= 1'b1;
          phase <= PH_IDLE;
        end
        default: begin
          if (ph_last) begin
            phase <= nxt_ph;
            if (nxt_ph == PH_DONE) cs_n <= 1'b1;
            else begin
              w        <= nxt_w;
              clk_left <= clocks_per_byte(nxt_w);
              byt_left <= nxt_cnt;
            end
            if (nxt_ph == PH_ADR) adr_sh <= {adr_sh[23:0], 8'h00};
          end else if (last_clk) begin
            clk_left <= clocks_per_byte(w);
            byt_left <= byt_left - CNT_W'(1);
            if (phase == PH_ADR) adr_sh <= {adr_sh[23:0], 8'h00};
          end else if (fall) begin
            clk_left <= clk_left - 4'd1;
          end
        end
      endcase
    end
  end

  // ---------------- assertions ----------------
  a_r8_clock_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n) else $error("sclk high while deselected");

  a_r8_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> done) else $error("done did not follow cs_n release");

  a_r2_refused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cs_n && !done)) else $error("refused start touched the bus");

  a_r7_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(lane_out)) else $error("lanes moved while sclk high");

  a_r6_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (lane_oe == 4'h0)) else $error("lanes driven during read");

  a_r1_enable_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_oe != 4'h0) |-> (lane_oe == 4'h1 || lane_oe == 4'h3 || lane_oe == 4'hF))
    else $error("illegal lane enable pattern");

endmodule

// File: tb/flash_lane_engine_test.sv
module flash_lane_engine_test;
  localparam int HALF = 2;
  localparam int LW   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] io_mode = 3'd0;
  logic addr_en = 1'b0, addr4 = 1'b0, data_en = 1'b0, rd_nwr = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [31:0] addr = 32'h0;
  logic [2:0] dummy_bytes = 3'd0;
  logic [LW-1:0] data_len_m1 = '0;
  logic [7:0] wr_data;
  logic wr_ack, rd_valid, done, err, sclk, cs_n;
  logic [7:0] rd_data;
  logic [3:0] lane_out, lane_oe;
  logic [3:0] lane_in = 4'h0;

  always #5 clk = ~clk;

  flash_lane_engine #(.HALF_DIV(HALF), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .io_mode(io_mode), .addr_en(addr_en),
    .addr4(addr4), .opcode(opcode), .addr(addr), .dummy_bytes(dummy_bytes),
    .data_en(data_en), .rd_nwr(rd_nwr), .data_len_m1(data_len_m1), .wr_data(wr_data),
    .wr_ack(wr_ack), .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .err(err),
    .sclk(sclk), .cs_n(cs_n), .lane_out(lane_out), .lane_oe(lane_oe), .lane_in(lane_in)
  );

  int checks = 0, fails = 0;
  logic [7:0] wr_mem [0:15];
  logic [7:0] rd_mem [0:15];
  logic [3:0] exp_out [0:255];
  logic [3:0] exp_oe  [0:255];
  int exp_n;
  int rd_start, rd_l;
  logic rd_on = 1'b0;

  // monitor state
  logic clr = 1'b0;
  int rise_n, ack_n, rd_n, done_n, err_n, cs_bad, hold_bad, hi_bad, hi_len, cs_low_n;
  logic [3:0] cap_out [0:255];
  logic [3:0] cap_oe  [0:255];
  logic [7:0] rd_got  [0:15];
  logic prev_sclk = 1'b0;
  logic [3:0] prev_out = 4'h0;

  assign wr_data = wr_mem[ack_n % 16];

  function automatic logic [3:0] flash_bits(int k);
    int j, per, g, v;
    if (!rd_on || k < rd_start) return 4'h0;
    j   = k - rd_start;
    per = 8 / rd_l;
    g   = j % per;
    v   = (int'(rd_mem[(j / per) % 16]) >> (8 - rd_l * (g + 1))) & ((1 << rd_l) - 1);
    if (rd_l == 1) return {2'b00, v[0], 1'b0};
    return v[3:0];
  endfunction

  always @(negedge clk) begin
    if (clr) begin
      rise_n = 0; ack_n = 0; rd_n = 0; done_n = 0; err_n = 0; cs_bad = 0;
      hold_bad = 0; hi_bad = 0; hi_len = 0; cs_low_n = 0;
      lane_in = 4'h0;
    end else begin
      if (sclk && !prev_sclk) begin
        if (rise_n < 256) begin
          cap_out[rise_n] = lane_out;
          cap_oe[rise_n]  = lane_oe;
        end
        rise_n = rise_n + 1;
        lane_in = flash_bits(rise_n);
      end
      if (sclk && prev_sclk && lane_out != prev_out) hold_bad = hold_bad + 1;
      if (sclk) hi_len = hi_len + 1;
      else if (prev_sclk) begin
        if (hi_len != HALF) hi_bad = hi_bad + 1;
        hi_len = 0;
      end
      if (sclk && cs_n) cs_bad = cs_bad + 1;
      if (!cs_n) cs_low_n = cs_low_n + 1;
      if (wr_ack) ack_n = ack_n + 1;
      if (rd_valid) begin
        if (rd_n < 16) rd_got[rd_n] = rd_data;
        rd_n = rd_n + 1;
      end
      if (done) done_n = done_n + 1;
      if (err) err_n = err_n + 1;
    end
    prev_sclk = sclk;
    prev_out  = lane_out;
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      $display("FAIL R8 watchdog expired act=%0d exp=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input int l, input bit drive);
    int v;
    for (int g = 0; g < 8 / l; g++) begin
      v = (int'(b) >> (8 - l * (g + 1))) & ((1 << l) - 1);
      exp_oe[exp_n]  = drive ? 4'((1 << l) - 1) : 4'h0;
      exp_out[exp_n] = drive ? v[3:0] : 4'h0;
      exp_n++;
    end
  endtask

  task automatic clear_mon();
    @(posedge clk); clr = 1'b1;
    @(posedge clk); clr = 1'b0;
  endtask

  task automatic run_cmd(input string name, input logic [2:0] m, input bit ae, input bit a4,
                         input logic [7:0] op, input logic [31:0] ad, input logic [2:0] dm,
                         input bit de, input bit rd, input int lm1, input int poke);
    int lo, la, ld, bad, tmo;
    lo = (m == 3) ? 2 : (m == 7) ? 4 : 1;
    la = (m == 2 || m == 3) ? 2 : (m == 6 || m == 7) ? 4 : 1;
    ld = (m == 0) ? 1 : (m < 4) ? 2 : 4;
    exp_n = 0;
    push(op, lo, 1'b1);
    if (ae) begin
      if (a4) push(ad[31:24], la, 1'b1);
      push(ad[23:16], la, 1'b1);
      push(ad[15:8], la, 1'b1);
      push(ad[7:0], la, 1'b1);
    end
    for (int i = 0; i < int'(dm); i++) push(8'h00, ld, 1'b0);
    rd_start = exp_n;
    rd_l     = ld;
    rd_on    = de && rd;
    if (de) for (int i = 0; i <= lm1; i++) push(rd ? 8'h00 : wr_mem[i], ld, !rd);
    clear_mon();
    @(negedge clk);
    io_mode = m; addr_en = ae; addr4 = a4; opcode = op; addr = ad; dummy_bytes = dm;
    data_en = de; rd_nwr = rd; data_len_m1 = LW'(lm1); start = 1'b1;
    @(negedge clk); start = 1'b0;
    tmo = 0;
    while (done_n == 0 && tmo < 3000) begin
      @(posedge clk);
      tmo++;
      if (poke > 0 && tmo == poke) begin
        // R9: second start in the middle of the command
        @(negedge clk); start = 1'b1; io_mode = 3'd7; opcode = 8'hFF;
        @(negedge clk); start = 1'b0;
      end
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(done_n == 1, {name, " R8 done pulse count"}, done_n, 1);
    chk(err_n == 0, {name, " R2 no error on valid mode"}, err_n, 0);
    chk(rise_n == exp_n, {name, " R1 R3 R5 serial clock count"}, rise_n, exp_n);
    bad = -1;
    for (int i = 0; i < exp_n && i < rise_n; i++)
      if (bad < 0 && (cap_out[i] != exp_out[i] || cap_oe[i] != exp_oe[i])) bad = i;
    chk(bad < 0, {name, " R1 R4 R5 R6 lane stream (oe,out at first bad clock)"},
        (bad < 0) ? 0 : int'({cap_oe[bad], cap_out[bad]}),
        (bad < 0) ? 0 : int'({exp_oe[bad], exp_out[bad]}));
    chk(cs_bad == 0 && cs_n == 1'b1, {name, " R8 chip select framing"}, cs_bad, 0);
    chk(hold_bad == 0 && hi_bad == 0, {name, " R7 mode 0 timing"}, hold_bad + hi_bad, 0);
    if (de && rd) begin
      chk(rd_n == lm1 + 1, {name, " R6 read byte count"}, rd_n, lm1 + 1);
      for (int i = 0; i <= lm1 && i < rd_n; i++)
        chk(rd_got[i] == rd_mem[i], {name, " R6 read byte value"}, rd_got[i], rd_mem[i]);
    end else begin
      chk(ack_n == (de ? lm1 + 1 : 0), {name, " R6 write byte acks"}, ack_n, de ? lm1 + 1 : 0);
      chk(rd_n == 0, {name, " R6 no read strobes"}, rd_n, 0);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cs_n == 1'b1, "R10 cs_n after reset", cs_n, 1);
    chk(sclk == 1'b0 && lane_oe == 4'h0, "R10 bus idle after reset", {sclk, lane_oe}, 0);
    chk({done, err, wr_ack, rd_valid} == 4'h0, "R10 strobes low after reset",
        {done, err, wr_ack, rd_valid}, 0);
  endtask

  task automatic t_bad_mode();
    clear_mon();
    @(negedge clk);
    io_mode = 3'd4; addr_en = 1'b1; data_en = 1'b1; rd_nwr = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(err_n == 1, "R2 error pulse on mode 4", err_n, 1);
    chk(cs_low_n == 0 && rise_n == 0, "R2 bus untouched on mode 4", cs_low_n + rise_n, 0);
    chk(done_n == 0, "R2 no done on mode 4", done_n, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      wr_mem[i] = 8'(8'h3C + i * 37);
      rd_mem[i] = 8'(8'hA5 ^ (i * 29));
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    // single lane read, 3-byte address, one dummy byte (R1 R3 R5 R6)
    run_cmd("std_read", 3'd0, 1'b1, 1'b0, 8'h0B, 32'hFF12_3456, 3'd1, 1'b1, 1'b1, 3, 0);
    // dual data read, 4-byte address on one lane
    run_cmd("dual_data_read", 3'd1, 1'b1, 1'b1, 8'h3C, 32'h89AB_CDEF, 3'd1, 1'b1, 1'b1, 2, 0);
    // dual I/O write
    run_cmd("dual_io_write", 3'd2, 1'b1, 1'b0, 8'hA2, 32'h0055_AA33, 3'd0, 1'b1, 1'b0, 2, 0);
    // full dual, no address, no data
    run_cmd("full_dual_opc", 3'd3, 1'b0, 1'b0, 8'hC7, 32'h0, 3'd0, 1'b0, 1'b0, 0, 0);
    // quad data write, no dummy
    run_cmd("quad_data_write", 3'd5, 1'b1, 1'b0, 8'h32, 32'h0001_0203, 3'd0, 1'b1, 1'b0, 4, 0);
    // quad I/O read, 4-byte address, 3 dummy bytes = 6 clocks
    run_cmd("quad_io_read", 3'd6, 1'b1, 1'b1, 8'hEC, 32'h1357_9BDF, 3'd3, 1'b1, 1'b1, 4, 0);
    // full quad read with dummy, no address
    run_cmd("full_quad_read", 3'd7, 1'b0, 1'b0, 8'h6B, 32'h0, 3'd2, 1'b1, 1'b1, 1, 0);
    // start while busy is ignored (R9)
    run_cmd("R9_busy_start", 3'd0, 1'b1, 1'b0, 8'h02, 32'h0024_6801, 3'd0, 1'b1, 1'b0, 1, 20);
    t_bad_mode();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule